// File: doc/BRIEF.md
# I2C Slave Receiver with 10-bit Address Match

This block is the slave side of an I2C bus for a device that answers to a 10-bit address and only takes write data from a bus master. The open-drain SDA and SCL lines are modelled as a line input plus an active-high pull-low enable. The block oversamples both lines on the system clock and finds START, STOP and repeated START from the synchronized samples. It compares the two-byte 10-bit address header with an address held in its registers, acknowledges matching bytes, and passes each received data byte to a host through a small register file.

The host sees four byte-wide registers, selected by `host_addr`:

- offset 0: received data (read only).
- offset 1: status. Bit 0 is receive-full, bit 1 is address-matched, bit 2 is stop-seen, and bit 3 is the captured R/W bit.
- offset 2: control. Bit 0 is enable, bit 1 is not-acknowledge request, and bits 5:4 are address bits [9:8].
- offset 3: address bits [7:0].

`irq` is high while any of the status bits 0 to 2 is set. A read of the data register clears receive-full. A read of the status register clears address-matched and stop-seen. When a new data byte is complete while the previous one has not yet been read, the slave holds SCL low until the host reads the data register.

Top module: `i2c10_slave`

## Requirements
- R1: After reset the status register reads 0x00, and `sda_oe`, `scl_oe` and `irq` are all 0.
- R2: The slave acknowledges the first byte after a START only when that byte is {5'b11110, addr[9:8], 1'b0} (MSB first, R/W last). For any other byte it leaves SDA released in the acknowledge slot.
- R3: After an accepted first byte, the second byte is acknowledged only if it equals addr[7:0]. On that match, status bit 1 is set and `irq` rises.
- R4: A host read of the status register (offset 1) clears status bits 1 and 2.
- R5: Each byte received after an address match is written to the data register (offset 0). Status bit 0 is then set, `irq` is raised, and the byte is acknowledged.
- R6: A host read of the data register clears status bit 0.
- R7: When control bit 1 is set, the next data byte is answered with a not-acknowledge and control bit 1 returns to 0. Later bytes are acknowledged again.
- R8: If status bit 0 is still set when a new data byte completes, `scl_oe` is held at 1 from the falling SCL edge after the eighth bit until the host reads the data register. The new byte is then loaded and SCL is released.
- R9: A STOP, or a repeated START, that arrives once the address has matched sets status bit 2.
- R10: While control bit 0 is 0, the slave does not acknowledge any byte, sets no status bit, and keeps `sda_oe` and `scl_oe` at 0.
- R11: Status bit 3 holds the R/W bit of the most recent first address byte whose upper seven bits matched. If that R/W bit is 1, the byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock hold) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; clears flags on read |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for `host_addr` |
| irq | output | 1 | Interrupt, any of status bits 0 to 2 set |

## Verification
The assertions assume a well-behaved bus master, with three limits:

- SDA changes only while SCL is low, except when the master forms a START or a STOP.
- Every change on a line lasts several system clocks longer than the two-stage synchronizer plus the edge register.
- The master does not raise SCL while the slave is pulling it low.

The stimulus follows all three. Line changes are driven only on falling system-clock edges, in quarter-bit steps of six clocks. Before going on after releasing SCL, the master waits until the line is actually high. Host strobes last one cycle, and the register values are captured between clock edges.

// File: rtl/i2c10s_pkg.sv
package i2c10s_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 10;
    localparam int HI_W     = ADDR_W - BYTE_W;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int PFX_W    = BYTE_W - HI_W - 1;

    localparam logic [PFX_W-1:0] HDR_PREFIX = 5'b11110;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_ADDR = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_HI,
        ST_ACK_HI,
        ST_ADR_LO,
        ST_ACK_LO,
        ST_DATA,
        ST_HOLD,
        ST_ACK_DAT,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic              en;
        logic              nak;
        logic [HI_W-1:0]   addr_hi;
        logic [BYTE_W-1:0] addr_lo;
    } cfg_t;

    typedef struct packed {
        logic              rx_load;
        logic [BYTE_W-1:0] rx_byte;
        logic              match_set;
        logic              stop_set;
        logic              dir_set;
        logic              dir_val;
        logic              nak_used;
    } evt_t;

    // upper seven bits of a 10-bit header: prefix plus address bits [9:8]
    function automatic logic hdr_hit(input logic [BYTE_W-1:0] b,
                                     input logic [HI_W-1:0]   hi);
        return (b[BYTE_W-1 -: PFX_W] == HDR_PREFIX) && (b[HI_W:1] == hi);
    endfunction

    // states after the full address matched
    function automatic logic is_addressed(input rx_state_e s);
        return (s == ST_ACK_LO) || (s == ST_DATA) ||
               (s == ST_HOLD)   || (s == ST_ACK_DAT);
    endfunction

endpackage

// File: rtl/i2c10s_line_sync.sv
module i2c10s_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
                    sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c10s_rx_fsm.sv
module i2c10s_rx_fsm
    import i2c10s_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  logic rx_full,
    input  logic sda_s,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    output evt_t ev,
    output logic sda_oe,
    output logic scl_oe
);

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;

    assign byte_done = scl_fall && (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        ev <= '0;
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (!cfg.en) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (start_det) begin
            if (is_addressed(st)) ev.stop_set <= 1'b1;
            st     <= ST_ADR_HI;
            cnt    <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (stop_det) begin
            if (is_addressed(st)) ev.stop_set <= 1'b1;
            st     <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else begin
            if (scl_rise && (cnt != CNT_W'(BYTE_W))) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
                cnt   <= cnt + 1'b1;
            end
            unique case (st)
                ST_ADR_HI: if (byte_done) begin
                    if (hdr_hit(shreg, cfg.addr_hi)) begin
                        ev.dir_set <= 1'b1;
                        ev.dir_val <= shreg[0];
                    end
                    if (hdr_hit(shreg, cfg.addr_hi) && !shreg[0]) begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK_HI;
                    end else begin
                        st     <= ST_SKIP;
                    end
                end
                ST_ACK_HI: if (scl_fall) begin
                    sda_oe <= 1'b0;
                    cnt    <= '0;
                    st     <= ST_ADR_LO;
                end
                ST_ADR_LO: if (byte_done) begin
                    if (shreg == cfg.addr_lo) begin
                        sda_oe       <= 1'b1;
                        ev.match_set <= 1'b1;
                        st           <= ST_ACK_LO;
                    end else begin
                        st           <= ST_SKIP;
                    end
                end
                ST_ACK_LO, ST_ACK_DAT: if (scl_fall) begin
                    sda_oe <= 1'b0;
                    cnt    <= '0;
                    st     <= ST_DATA;
                end
                ST_DATA: if (byte_done) begin
                    st <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (rx_full) begin
                        scl_oe <= 1'b1;
                    end else begin
                        scl_oe      <= 1'b0;
                        ev.rx_load  <= 1'b1;
                        ev.rx_byte  <= shreg;
                        ev.nak_used <= cfg.nak;
                        sda_oe      <= !cfg.nak;
                        st          <= ST_ACK_DAT;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (!sda_oe && !scl_oe)); // R10

    AST_HOLD_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && !rx_full) |=> !scl_oe); // R8

endmodule

// File: rtl/i2c10s_host_regs.sv
module i2c10s_host_regs
    import i2c10s_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    input  evt_t              ev,
    output cfg_t              cfg,
    output logic              rx_full,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              irq
);

    logic [BYTE_W-1:0] rx_data;
    logic              f_match;
    logic              f_stop;
    logic              f_dir;
    logic              wr_ctrl;
    logic              rd_stat;
    logic              rd_data;

    assign wr_ctrl = host_wr && (host_addr == REG_CTRL);
    assign rd_stat = host_rd && (host_addr == REG_STAT);
    assign rd_data = host_rd && (host_addr == REG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            rx_data <= '0;
            rx_full <= 1'b0;
            f_match <= 1'b0;
            f_stop  <= 1'b0;
            f_dir   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cfg.en      <= host_wdata[0];
                cfg.nak     <= host_wdata[1];
                cfg.addr_hi <= host_wdata[5:4];
            end else if (ev.nak_used) begin
                cfg.nak     <= 1'b0;
            end
            if (host_wr && (host_addr == REG_ADDR)) cfg.addr_lo <= host_wdata;

            if (ev.rx_load) begin
                rx_data <= ev.rx_byte;
                rx_full <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end

            if (ev.match_set)   f_match <= 1'b1;
            else if (rd_stat)   f_match <= 1'b0;

            if (ev.stop_set)    f_stop  <= 1'b1;
            else if (rd_stat)   f_stop  <= 1'b0;

            if (ev.dir_set)     f_dir   <= ev.dir_val;
        end
    end

    always_comb begin
        unique case (host_addr)
            REG_DATA: host_rdata = rx_data;
            REG_STAT: host_rdata = {4'b0, f_dir, f_stop, f_match, rx_full};
            REG_CTRL: host_rdata = {2'b0, cfg.addr_hi, 2'b0, cfg.nak, cfg.en};
            default:  host_rdata = cfg.addr_lo;
        endcase
    end

    assign irq = rx_full | f_match | f_stop;

    AST_MATCH_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        ev.match_set |=> (f_match && irq)); // R3

    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !ev.match_set && !ev.stop_set) |=> (!f_match && !f_stop)); // R4

    AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        ev.rx_load |=> (rx_full && irq)); // R5

    AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !ev.rx_load) |=> !rx_full); // R6

    AST_NAK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (ev.nak_used && !wr_ctrl) |=> !cfg.nak); // R7

endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave
    import i2c10s_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       irq
);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    cfg_t cfg;
    evt_t ev;
    logic rx_full;

    i2c10s_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c10s_rx_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .rx_full   (rx_full),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ev        (ev),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe)
    );

    i2c10s_host_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .ev         (ev),
        .cfg        (cfg),
        .rx_full    (rx_full),
        .host_rdata (host_rdata),
        .irq        (irq)
    );

endmodule

// File: tb/i2c10_slave_tb_top.sv
`timescale 1ns/1ps
module i2c10_slave_tb_top;

    localparam int Q = 6;
    localparam logic [9:0] OWN = 10'h2B5;
    localparam logic [7:0] HDR_W = {5'b11110, OWN[9:8], 1'b0};
    localparam logic [7:0] CTRL_ON = {2'b00, OWN[9:8], 4'b0001};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b0, m_sda = 1'b0;
    logic scl_oe, sda_oe, irq;
    logic [1:0] host_addr = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    wire scl_line = !(m_scl | scl_oe);
    wire sda_line = !(m_sda | sda_oe);

    int vectors = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c10_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        for (int i = 0; i < 4000 && !scl_line; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b0; m_scl = 1'b0; qwait();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; wait_scl_high(); qwait();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b1; qwait();
        m_scl = 1'b0; wait_scl_high(); qwait();
        m_sda = 1'b0; qwait(); qwait();
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = !b[i]; qwait();
            m_scl = 1'b0; wait_scl_high(); qwait(); qwait();
            m_scl = 1'b1; qwait();
        end
    endtask

    task automatic ack_clk(output bit acked);
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; wait_scl_high(); qwait();
        acked = !sda_line;
        qwait();
        m_scl = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b);
        ack_clk(acked);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit ak;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        host_read(2'd1, d);
        check("R1 status after reset", d, 8'h00);
        check("R1 sda_oe after reset", sda_oe, 1'b0);
        check("R1 scl_oe after reset", scl_oe, 1'b0);
        check("R1 irq after reset", irq, 1'b0);

        host_write(2'd3, OWN[7:0]);
        host_write(2'd2, CTRL_ON);

        // R2: every possible first header byte
        for (int b = 0; b < 256; b++) begin
            bit exp;
            exp = ((b >> 3) == 5'h1E) && (((b >> 1) & 3) == OWN[9:8]) && ((b & 1) == 0);
            bus_start();
            send_byte(8'(b), ak);
            check($sformatf("R2 header byte %02h ack", b), ak, exp);
            bus_stop();
        end

        // R3/R4/R9: second header byte sweep
        for (int k = 0; k < 32; k++) begin
            logic [7:0] v;
            bit hit;
            v = 8'hB5 ^ 8'(k * 37);
            hit = (v == OWN[7:0]);
            bus_start();
            send_byte(HDR_W, ak);
            send_byte(v, ak);
            check($sformatf("R3 low byte %02h ack", v), ak, hit);
            host_read(2'd1, d);
            check("R3 match flag", d, hit ? 8'h02 : 8'h00);
            bus_stop();
            host_read(2'd1, d);
            check("R4 R9 status after stop", d, hit ? 8'h04 : 8'h00);
            host_read(2'd1, d);
            check("R4 status cleared", d, 8'h00);
        end

        // R5/R6 data bytes
        bus_start();
        send_byte(HDR_W, ak);
        send_byte(OWN[7:0], ak);
        host_read(2'd1, d);
        foreach (d[i]) ;
        for (int j = 0; j < 3; j++) begin
            logic [7:0] v;
            v = 8'(8'h3C + j * 8'h6B);
            send_byte(v, ak);
            check("R5 data ack", ak, 1'b1);
            check("R5 irq on data", irq, 1'b1);
            host_read(2'd1, d);
            check("R5 rx full flag", d, 8'h01);
            host_read(2'd0, d);
            check("R5 data value", d, v);
            host_read(2'd1, d);
            check("R6 rx full cleared", d, 8'h00);
            check("R6 irq cleared", irq, 1'b0);
        end

        // R7 one-shot NAK
        host_write(2'd2, CTRL_ON | 8'h02);
        send_byte(8'h55, ak);
        check("R7 nak applied", ak, 1'b0);
        host_read(2'd2, d);
        check("R7 nak bit self-clears", d, CTRL_ON);
        host_read(2'd0, d);
        check("R7 nak byte still stored", d, 8'h55);
        send_byte(8'h66, ak);
        check("R7 next byte acked", ak, 1'b1);
        host_read(2'd0, d);

        // R8 clock hold
        send_byte(8'h81, ak);
        send_bits(8'h42);
        repeat (20) @(negedge clk);
        check("R8 scl held while full", scl_oe, 1'b1);
        check("R8 scl line low", scl_line, 1'b0);
        host_read(2'd0, d);
        check("R8 first byte read", d, 8'h81);
        repeat (10) @(negedge clk);
        check("R8 scl released after read", scl_oe, 1'b0);
        ack_clk(ak);
        check("R8 held byte acked", ak, 1'b1);
        host_read(2'd0, d);
        check("R8 held byte value", d, 8'h42);

        // R9 repeated start
        bus_rstart();
        send_byte(HDR_W, ak);
        host_read(2'd1, d);
        check("R9 repeated start sets stop flag", d, 8'h04);
        send_byte(OWN[7:0], ak);
        bus_stop();
        host_read(2'd1, d);
        check("R9 stop after match", d, 8'h06);

        // R11 direction bit
        bus_start();
        send_byte(HDR_W | 8'h01, ak);
        check("R11 read header not acked", ak, 1'b0);
        bus_stop();
        host_read(2'd1, d);
        check("R11 dir bit captured", d, 8'h08);

        // R10 disabled
        host_write(2'd2, CTRL_ON & 8'hFE);
        bus_start();
        send_byte(HDR_W, ak);
        check("R10 no ack when off", ak, 1'b0);
        send_byte(OWN[7:0], ak);
        check("R10 no ack low byte when off", ak, 1'b0);
        bus_stop();
        host_read(2'd1, d);
        check("R10 no flags when off", d & 8'h07, 8'h00);
        check("R10 irq low when off", irq, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule